// File: doc/BRIEF.md
# Touch-Screen ADC Host Sequencer

This block is the host side of a serial link to a touch-screen conversion chip. It makes a mode-0 serial clock from the system clock with a divider and pulls chip-select low. It shifts out an 8-bit command that opens with a start bit, waits for the chip's busy line to fall, and clocks in a 16-bit reply. It returns the 12-bit sample with a one-cycle valid strobe.

Touch panels with filter capacitors settle slowly, and the block handles this in two ways. First, one request can run a burst of back-to-back conversions on the same channel. Only the last conversion of the burst carries the power-down code, and only its result is reported. Second, the serial clock can be held low for a programmable number of system cycles in the middle of each command, which lengthens the acquisition window. If the chip never drops busy, a watchdog ends the transaction and flags an error.

Top module: `touch_adc_host`

## Requirements
- R1: After reset and while idle, `cs_n` is 1, `sclk` is 0, `mosi` is 0, and `result_valid` and `timeout_err` are 0.
- R2: The serial clock stays low whenever `cs_n` is high. Each high phase lasts HALF_DIV system cycles. `mosi` changes only while `sclk` is low, so the chip can sample it on rising edges.
- R3: The command is sent MSB first. Bit 7 is 1, bits 6:4 are the channel, bit 3 is 0 (12-bit resolution), and bit 2 is the single-ended flag (0 = differential). `mosi` is 1 in the cycle chip-select falls.
- R4: A request with `repeat_m1` = N runs N+1 conversions, all with the same channel and mode. `cs_n` stays low from the first command to the end of the last read.
- R5: Command bits 1:0 are 2'b11 (stay powered) on every conversion except the last. On the last conversion they are 2'b00 (power down afterwards).
- R6: Once busy falls, 16 rising edges of `sclk` sample `miso`. `result` is the first 12 bits received, with the first bit as the MSB.
- R7: `result_valid` pulses for exactly one cycle per completed request, after the final conversion only. It pulses in the same cycle that `cs_n` rises.
- R8: In each command, the low phase before the sixth rising edge of `sclk` lasts HALF_DIV + `hold_len` system cycles. All other low phases last HALF_DIV cycles.
- R9: If busy does not fall within TIMEOUT_CYC cycles after a command ends, `cs_n` rises, `timeout_err` is set, and no valid strobe is given.
- R10: `timeout_err` clears when the next request is accepted. A `start` that arrives while a request is running is ignored. Channel, mode, repeat count and hold length are captured at acceptance, so later changes to those inputs have no effect on the running request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request a conversion burst (accepted when idle) |
| chan_sel | input | 3 | Channel address for the burst |
| single_ended | input | 1 | 1 = single-ended, 0 = differential |
| repeat_m1 | input | REP_W | Number of conversions minus one |
| hold_len | input | HOLD_W | Extra system cycles the clock is held low in each command |
| sclk | output | 1 | Serial clock, idles low |
| cs_n | output | 1 | Active-low chip-select |
| mosi | output | 1 | Command data to the chip |
| miso | input | 1 | Reply data from the chip |
| busy_in | input | 1 | Busy line from the chip |
| result | output | 12 | Result of the last conversion of the burst |
| result_valid | output | 1 | One-cycle strobe for `result` |
| timeout_err | output | 1 | Busy-wait watchdog expired on the last request |

## Verification
The properties assume two things about the inputs: `busy_in` and `miso` change only while chip-select is low, and `start` is a single-cycle pulse. Beyond that they depend only on the block's own outputs. The bench's chip model updates `busy_in` and `miso` on the falling system-clock edge, only in response to `sclk` edges seen while selected. It clears both whenever chip-select is high. Conversion times are drawn at random but kept well below the watchdog limit, except in the one case that holds busy high on purpose to test the timeout.

// File: rtl/tsh_pkg.sv
package tsh_pkg;

    localparam int CMD_BITS  = 8;
    localparam int READ_BITS = 16;
    localparam int RES_BITS  = 12;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_HOLD,
        ST_WAIT,
        ST_READ
    } tsh_state_e;

    // Command byte: start bit, channel, resolution (0 = 12 bit),
    // single-ended flag, power code (11 keep on, 00 power down at end).
    function automatic logic [CMD_BITS-1:0] tsh_cmd(input logic [2:0] ch,
                                                    input logic       se,
                                                    input logic       last);
        return {1'b1, ch, 1'b0, se, (last ? 2'b00 : 2'b11)};
    endfunction

endpackage

// File: rtl/tsh_div.sv
module tsh_div #(
    parameter int HALF_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = $clog2(HALF_DIV + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = run && (cnt_q == CW'(HALF_DIV - 1));
        cnt_d = (!run || tick) ? '0 : cnt_q + CW'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/tsh_busy_watch.sv
module tsh_busy_watch #(
    parameter int TIMEOUT_CYC = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic busy_in,
    input  logic arm,
    output logic fell,
    output logic expired
);
    localparam int TW = $clog2(TIMEOUT_CYC + 1);

    typedef struct packed {
        logic          s1;
        logic          s2;
        logic [TW-1:0] cnt;
    } bw_t;

    bw_t d, q;

    always_comb begin
        d       = q;
        d.s1    = busy_in;
        d.s2    = q.s1;
        fell    = arm && q.s2 && !q.s1;
        expired = arm && (q.cnt == TW'(TIMEOUT_CYC - 1));
        if (!arm)
            d.cnt = '0;
        else if (!expired)
            d.cnt = q.cnt + TW'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/tsh_rx_shift.sv
module tsh_rx_shift #(
    parameter int WIDTH = 16,
    parameter int KEEP  = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            shift_en,
    input  logic            din,
    output logic [KEEP-1:0] top_bits
);
    logic [WIDTH-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (clr)
            sh_d = '0;
        else if (shift_en)
            sh_d = {sh_q[WIDTH-2:0], din};
        top_bits = sh_q[WIDTH-1 -: KEEP];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end
endmodule

// File: rtl/touch_adc_host.sv
module touch_adc_host
    import tsh_pkg::*;
#(
    parameter int HALF_DIV    = 4,
    parameter int HOLD_W      = 8,
    parameter int REP_W       = 4,
    parameter int TIMEOUT_CYC = 4096,
    parameter int ACQ_BIT     = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [2:0]          chan_sel,
    input  logic                single_ended,
    input  logic [REP_W-1:0]    repeat_m1,
    input  logic [HOLD_W-1:0]   hold_len,
    output logic                sclk,
    output logic                cs_n,
    output logic                mosi,
    input  logic                miso,
    input  logic                busy_in,
    output logic [RES_BITS-1:0] result,
    output logic                result_valid,
    output logic                timeout_err
);
    localparam int BC_W = $clog2(READ_BITS);

    typedef struct packed {
        tsh_state_e            st;
        logic                  sclk;
        logic                  cs_n;
        logic [BC_W-1:0]       bit_cnt;
        logic [REP_W-1:0]      left;
        logic [2:0]            ch;
        logic                  se;
        logic [HOLD_W-1:0]     hold;
        logic [HOLD_W-1:0]     hold_cnt;
        logic [CMD_BITS-1:0]   cmd;
        logic [RES_BITS-1:0]   res;
        logic                  vld;
        logic                  err;
    } ctl_t;

    ctl_t d, q;

    logic                run, tick, fell, expired, rx_clr, rx_shift;
    logic [RES_BITS-1:0] rx_top;

    assign run = (q.st == ST_CMD) || (q.st == ST_READ);

    tsh_div #(.HALF_DIV(HALF_DIV)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .tick  (tick)
    );

    tsh_busy_watch #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_watch (
        .clk     (clk),
        .rst_n   (rst_n),
        .busy_in (busy_in),
        .arm     (q.st == ST_WAIT),
        .fell    (fell),
        .expired (expired)
    );

    assign rx_clr   = (q.st == ST_WAIT) && fell;
    assign rx_shift = (q.st == ST_READ) && tick && !q.sclk;

    tsh_rx_shift #(.WIDTH(READ_BITS), .KEEP(RES_BITS)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (rx_clr),
        .shift_en (rx_shift),
        .din      (miso),
        .top_bits (rx_top)
    );

    always_comb begin
        d     = q;
        d.vld = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (start) begin
                    d.ch      = chan_sel;
                    d.se      = single_ended;
                    d.left    = repeat_m1;
                    d.hold    = hold_len;
                    d.err     = 1'b0;
                    d.cmd     = tsh_cmd(chan_sel, single_ended, repeat_m1 == '0);
                    d.cs_n    = 1'b0;
                    d.sclk    = 1'b0;
                    d.bit_cnt = '0;
                    d.st      = ST_CMD;
                end
            end
            ST_CMD: begin
                if (tick) begin
                    if (!q.sclk) begin
                        d.sclk = 1'b1;
                    end else begin
                        d.sclk = 1'b0;
                        d.cmd  = {q.cmd[CMD_BITS-2:0], 1'b0};
                        if (q.bit_cnt == BC_W'(CMD_BITS - 1)) begin
                            d.bit_cnt = '0;
                            d.st      = ST_WAIT;
                        end else begin
                            d.bit_cnt = q.bit_cnt + BC_W'(1);
                            if ((q.bit_cnt + BC_W'(1) == BC_W'(ACQ_BIT)) &&
                                (q.hold != '0)) begin
                                d.hold_cnt = '0;
                                d.st       = ST_HOLD;
                            end
                        end
                    end
                end
            end
            ST_HOLD: begin
                if (q.hold_cnt == q.hold - HOLD_W'(1))
                    d.st = ST_CMD;
                else
                    d.hold_cnt = q.hold_cnt + HOLD_W'(1);
            end
            ST_WAIT: begin
                if (fell) begin
                    d.bit_cnt = '0;
                    d.st      = ST_READ;
                end else if (expired) begin
                    d.cs_n = 1'b1;
                    d.err  = 1'b1;
                    d.st   = ST_IDLE;
                end
            end
            ST_READ: begin
                if (tick) begin
                    if (!q.sclk) begin
                        d.sclk = 1'b1;
                    end else begin
                        d.sclk = 1'b0;
                        if (q.bit_cnt == BC_W'(READ_BITS - 1)) begin
                            d.bit_cnt = '0;
                            if (q.left == '0) begin
                                d.cs_n = 1'b1;
                                d.res  = rx_top;
                                d.vld  = 1'b1;
                                d.st   = ST_IDLE;
                            end else begin
                                d.left = q.left - REP_W'(1);
                                d.cmd  = tsh_cmd(q.ch, q.se, q.left == REP_W'(1));
                                d.st   = ST_CMD;
                            end
                        end else begin
                            d.bit_cnt = q.bit_cnt + BC_W'(1);
                        end
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= ST_IDLE;
            q.cs_n <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign sclk         = q.sclk;
    assign cs_n         = q.cs_n;
    assign mosi         = q.cmd[CMD_BITS-1];
    assign result       = q.res;
    assign result_valid = q.vld;
    assign timeout_err  = q.err;

endmodule

// File: rtl/tsh_checker.sv
module tsh_checker (
    input logic clk,
    input logic rst_n,
    input logic sclk,
    input logic cs_n,
    input logic mosi,
    input logic result_valid,
    input logic timeout_err
);
    // R2: clock parked low while deselected
    p_sclk_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);

    // R2: data held steady across a high phase
    p_mosi_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(mosi));

    // R3: start bit presented as soon as the chip is selected
    p_start_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> mosi);

    // R7: strobe lasts one cycle
    p_valid_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |=> !result_valid);

    // R7: strobe coincides with the end of the transaction
    p_valid_cs_r7: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |-> (cs_n && !$past(cs_n)));

    // R9: abort deselects and gives no result
    p_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout_err) |-> (cs_n && !result_valid));
endmodule

bind touch_adc_host tsh_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sclk         (sclk),
    .cs_n         (cs_n),
    .mosi         (mosi),
    .result_valid (result_valid),
    .timeout_err  (timeout_err)
);

// File: tb/touch_adc_host_tb.sv
`timescale 1ns/1ps
module touch_adc_host_tb;
    localparam int HALF    = 2;
    localparam int TIMEOUT = 200;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  chan_sel = 3'd0;
    logic        single_ended = 1'b0;
    logic [3:0]  repeat_m1 = 4'd0;
    logic [7:0]  hold_len = 8'd0;
    logic        sclk, cs_n, mosi;
    logic        miso = 1'b0;
    logic        busy_in = 1'b0;
    logic [11:0] result;
    logic        result_valid, timeout_err;

    always #2 clk = ~clk;

    touch_adc_host #(.HALF_DIV(HALF), .HOLD_W(8), .REP_W(4),
                     .TIMEOUT_CYC(TIMEOUT), .ACQ_BIT(5)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .chan_sel(chan_sel),
        .single_ended(single_ended), .repeat_m1(repeat_m1), .hold_len(hold_len),
        .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso), .busy_in(busy_in),
        .result(result), .result_valid(result_valid), .timeout_err(timeout_err)
    );

    int checks = 0;
    int fails  = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // ---------------- chip model ----------------
    logic [7:0]  cmds  [0:2047];
    logic [11:0] samp  [0:2047];
    int          low_meas [0:2047];
    int          ncmd = 0, bad_high = 0, idle_bad = 0;
    int          conv_len = 5;
    bit          hang = 0;
    logic        sclk_prev = 1'b0;
    int          low_run = 0, high_run = 0;
    int          dmode = 0, dbits = 0, dctr = 0, drd = 0, dcur = 0;
    logic [7:0]  dsh = 8'd0;
    logic [15:0] dword = 16'd0;

    always @(negedge clk) begin
        bit s_rise, s_fall;
        s_rise = (sclk === 1'b1) && !sclk_prev;
        s_fall = (sclk === 1'b0) && sclk_prev;
        if (s_fall && high_run != HALF) bad_high++;
        if (cs_n !== 1'b0) begin
            dmode = 0; dbits = 0; busy_in = 1'b0; miso = 1'b0;
        end else begin
            case (dmode)
                0: begin
                    if (s_rise) begin
                        if (dbits == 5) low_meas[ncmd] = low_run;
                        dsh = {dsh[6:0], mosi};
                        dbits++;
                    end else if (s_fall && dbits == 8) begin
                        cmds[ncmd] = dsh;
                        dcur = ncmd;
                        ncmd++;
                        dbits = 0;
                        busy_in = 1'b1;
                        dctr = conv_len;
                        dmode = 1;
                    end
                end
                1: begin
                    if (!hang) begin
                        if (dctr <= 1) begin
                            busy_in = 1'b0;
                            dword = {samp[dcur], 4'b0000};
                            miso = dword[15];
                            drd = 0;
                            dmode = 2;
                        end else dctr--;
                    end
                end
                default: begin
                    if (s_rise) begin
                        drd++;
                        if (drd == 16) dmode = 0;
                    end else if (s_fall && drd < 16) begin
                        miso = dword[15 - drd];
                    end
                end
            endcase
        end
        if (sclk === 1'b1) begin
            if (s_rise) high_run = 1; else high_run++;
        end else begin
            if (s_fall) low_run = 1; else low_run++;
        end
        sclk_prev = (sclk === 1'b1);
    end

    // ---------------- output monitor ----------------
    int          vld_cnt = 0, cs_rise = 0;
    logic        cs_prev = 1'b1;
    logic [11:0] last_res = 12'd0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (result_valid) begin vld_cnt++; last_res = result; end
            if (cs_n && !cs_prev) cs_rise++;
            if (cs_n && sclk) idle_bad++;
            cs_prev = cs_n;
        end
    end

    // ---------------- expected values ----------------
    function automatic logic [7:0] exp_cmd(input logic [2:0] ch, input logic se,
                                           input bit last);
        return {1'b1, ch, 1'b0, se, (last ? 2'b00 : 2'b11)};
    endfunction

    task automatic run_seq(input logic [2:0] ch, input logic se, input int rep,
                           input int hold, input bit hng, input bit disturb);
        int base, vb, cb, hb, n;
        base = ncmd; vb = vld_cnt; cb = cs_rise; hb = bad_high;
        for (int k = 0; k <= rep; k++) samp[base + k] = 12'($urandom);
        hang = hng;
        conv_len = 3 + int'($urandom % 38);
        @(negedge clk);
        chan_sel = ch; single_ended = se; repeat_m1 = rep[3:0];
        hold_len = hold[7:0]; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (disturb) begin
            while (ncmd == base) @(negedge clk);
            chan_sel = ~ch; single_ended = ~se; repeat_m1 = 4'd0; hold_len = 8'd0;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        n = 0;
        while (vld_cnt == vb && !timeout_err && n < 20000) begin
            @(negedge clk); n++;
        end
        repeat (4) @(negedge clk);
        if (hng) begin
            check(timeout_err == 1'b1, "R9", "error flag after stuck busy", timeout_err, 1);
            check(cs_n == 1'b1, "R9", "cs_n after abort", cs_n, 1);
            check(vld_cnt == vb, "R9", "valid strobes on abort", vld_cnt - vb, 0);
            check(ncmd - base == 1, "R9", "commands before abort", ncmd - base, 1);
        end else begin
            check(ncmd - base == rep + 1, "R4", "conversion count", ncmd - base, rep + 1);
            check(cs_rise - cb == 1, "R4", "cs_n rises per burst", cs_rise - cb, 1);
            for (int k = 0; k <= rep; k++) begin
                logic [7:0] e;
                e = exp_cmd(ch, se, k == rep);
                check(cmds[base + k][7:2] == e[7:2], "R3", "command upper bits",
                      int'(cmds[base + k][7:2]), int'(e[7:2]));
                check(cmds[base + k][1:0] == e[1:0], "R5", "power bits",
                      int'(cmds[base + k][1:0]), int'(e[1:0]));
            end
            check(last_res == samp[base + rep], "R6", "result word",
                  int'(last_res), int'(samp[base + rep]));
            check(vld_cnt - vb == 1, "R7", "valid strobes per burst", vld_cnt - vb, 1);
            check(timeout_err == 1'b0, "R10", "error flag after good burst", timeout_err, 0);
            check(low_meas[base] == HALF + hold, "R8", "stretched low phase",
                  low_meas[base], HALF + hold);
            check(bad_high == hb, "R2", "high phases of wrong length", bad_high - hb, 0);
        end
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL R4 watchdog: actual running expected finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    // ---------------- main ----------------
    initial begin
        void'($urandom(32'd2024));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(cs_n == 1'b1, "R1", "cs_n after reset", cs_n, 1);
        check(sclk == 1'b0, "R1", "sclk after reset", sclk, 0);
        check(mosi == 1'b0, "R1", "mosi after reset", mosi, 0);
        check(result_valid == 1'b0, "R1", "valid after reset", result_valid, 0);
        check(timeout_err == 1'b0, "R1", "error after reset", timeout_err, 0);

        // directed corners
        run_seq(3'd3, 1'b0, 0, 0, 1'b0, 1'b0);     // single conversion, no hold
        run_seq(3'd5, 1'b0, 15, 0, 1'b0, 1'b0);    // longest burst
        run_seq(3'd1, 1'b1, 2, 1, 1'b0, 1'b0);     // one-cycle hold
        run_seq(3'd6, 1'b0, 3, 255, 1'b0, 1'b0);   // longest hold
        run_seq(3'd2, 1'b0, 0, 0, 1'b1, 1'b0);     // R9 stuck busy
        run_seq(3'd4, 1'b0, 1, 3, 1'b0, 1'b0);     // R10 error cleared
        run_seq(3'd7, 1'b1, 3, 4, 1'b0, 1'b1);     // R10 late start ignored

        // random bursts
        for (int i = 0; i < 12; i++) begin
            run_seq(3'($urandom), 1'($urandom), int'($urandom % 8),
                    int'($urandom % 24), 1'b0, 1'b0);
        end

        check(idle_bad == 0, "R2", "sclk high while deselected", idle_bad, 0);
        check(cs_n == 1'b1 && mosi == 1'b0, "R1", "idle outputs at end",
              int'({cs_n, mosi}), 2);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule